// File: doc/BRIEF.md
# Address-sequence command detector

This block watches the access stream of a byte-wide memory with a 13-bit address. It looks for six read accesses in a row to a fixed list of addresses. The first five addresses are the same for both commands. The sixth address selects one of two commands: a nonvolatile save or a nonvolatile restore. When the series completes, the block raises a one-clock request pulse toward the nonvolatile sequencer. The series carries no data pattern; only the addresses and the read direction count.

One strobe arrives per completed access, and only accesses with chip enable active produce a strobe. The output-enable state has no part in the decision. A write in the middle of a series aborts it. So does a read to the wrong address. The detector then starts again from the first address. A low-supply flag blocks a save request but leaves restore untouched. While the sequencer reports busy, the detector stays idle.

Top module: `seq_cmd_detect`

## Requirements
- R1: The read addresses 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0 and then 0x0F0F, given as six consecutive strobed reads, produce one pulse on `save_req_o`.
- R2: The same five leading reads followed by a read of 0x0F0E produce one pulse on `restore_req_o`.
- R3: A strobed write (`acc_write_i`=1) at any point aborts the series. No request follows, and the write never counts as step one, even when its address is 0x0000.
- R4: A strobed read of any address other than the next expected one aborts the series. Matching starts again from 0x0000.
- R5: An aborting read whose address is 0x0000 counts as step one of a new series.
- R6: If `supply_low_i` is 1 on the cycle the sixth strobe is sampled, the save request is suppressed. A restore request is issued regardless of `supply_low_i`.
- R7: While `nv_busy_i` is 1, strobes are ignored and all progress is discarded, so a series broken by busy never completes. No request is raised on the cycle after a cycle with busy high.
- R8: A request is high for exactly one clock. It rises on the clock edge that samples the sixth strobe. At most one of the two requests is high at a time, and both are 0 during reset.
- R9: Cycles with `acc_valid_i`=0 leave the progress unchanged, so gaps between accesses are allowed.
- R10: After a request, the detector is back at the start. Repeating the sixth address then gives no further request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | One-cycle strobe per completed chip-enabled access |
| acc_addr_i | input | 13 | Address of the access |
| acc_write_i | input | 1 | 1 = write access, 0 = read access |
| supply_low_i | input | 1 | Low-supply inhibit; blocks save requests |
| nv_busy_i | input | 1 | Nonvolatile sequencer busy; holds the detector idle |
| save_req_o | output | 1 | One-clock save request |
| restore_req_o | output | 1 | One-clock restore request |

## Verification
Directed series check the two commands. Other directed series break the prefix at every position with a wrong read or with a write, which separates a correct abort from a detector that skips a step or accepts writes. A restart on 0x0000 shows whether the aborting access is reused as step one, and a sixth address that is off by one bit checks the final compare. Random traffic that mostly follows the expected address, mixed with writes, stray addresses, idle gaps, supply-low and busy, is compared step by step against a bench model. This catches ordering and reset-of-progress faults that no single directed case reaches.

// File: rtl/seq_cmd_pkg.sv
package seq_cmd_pkg;
  localparam int unsigned ADDR_W   = 13;
  localparam int unsigned PREFIX_N = 5;

  localparam logic [15:0] KEY_SAVE    = 16'h0F0F;
  localparam logic [15:0] KEY_RESTORE = 16'h0F0E;

  // Leading addresses common to both commands, in the order they must occur
  function automatic logic [15:0] prefix_key(input int unsigned idx);
    case (idx)
      0:       return 16'h0000;
      1:       return 16'h1555;
      2:       return 16'h0AAA;
      3:       return 16'h1FFF;
      default: return 16'h10F0;
    endcase
  endfunction
endpackage

// File: rtl/seq_key_match.sv
module seq_key_match
  import seq_cmd_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned PN = PREFIX_N
) (
  input  logic [AW-1:0] addr_i,
  output logic [PN-1:0] prefix_hit_o,
  output logic          save_hit_o,
  output logic          restore_hit_o
);
  for (genvar g = 0; g < PN; g++) begin : g_prefix
    assign prefix_hit_o[g] = (addr_i == AW'(prefix_key(g)));
  end

  assign save_hit_o    = (addr_i == AW'(KEY_SAVE));
  assign restore_hit_o = (addr_i == AW'(KEY_RESTORE));
endmodule

// File: rtl/seq_step_tracker.sv
module seq_step_tracker #(
  parameter int unsigned PN     = 5,
  localparam int unsigned STEP_W = $clog2(PN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              write_i,
  input  logic              busy_i,
  input  logic [PN-1:0]     prefix_hit_i,
  input  logic              save_hit_i,
  input  logic              restore_hit_i,
  output logic [STEP_W-1:0] step_o,
  output logic              fire_save_o,
  output logic              fire_restore_o
);
  localparam int unsigned HW = 1 << STEP_W;
  localparam logic [STEP_W-1:0] LAST = STEP_W'(PN);

  logic [STEP_W-1:0] step_q, step_d;
  logic [HW-1:0]     hit_ext;
  logic              rd_acc, at_last, expect_hit;

  assign hit_ext    = {{(HW - PN){1'b0}}, prefix_hit_i};
  assign rd_acc     = valid_i && !write_i && !busy_i;
  assign at_last    = (step_q == LAST);
  assign expect_hit = hit_ext[step_q];

  assign fire_save_o    = rd_acc && at_last && save_hit_i;
  assign fire_restore_o = rd_acc && at_last && restore_hit_i;

  always_comb begin
    step_d = step_q;
    if (busy_i) begin
      step_d = '0;
    end else if (valid_i) begin
      if (write_i)                       step_d = '0;
      else if (!at_last && expect_hit)   step_d = step_q + 1'b1;
      else if (fire_save_o || fire_restore_o) step_d = '0;
      else if (prefix_hit_i[0])          step_d = STEP_W'(1); // restart on first key
      else                               step_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_q <= '0;
    else         step_q <= step_d;
  end

  assign step_o = step_q;
endmodule

// File: rtl/seq_req_stage.sv
module seq_req_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_save_i,
  input  logic fire_restore_i,
  input  logic supply_low_i,
  output logic save_req_o,
  output logic restore_req_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      save_req_o    <= 1'b0;
      restore_req_o <= 1'b0;
    end else begin
      save_req_o    <= fire_save_i && !supply_low_i;
      restore_req_o <= fire_restore_i;
    end
  end
endmodule

// File: rtl/seq_cmd_detect.sv
module seq_cmd_detect
  import seq_cmd_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned PN = PREFIX_N,
  localparam int unsigned STEP_W = $clog2(PN + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_valid_i,
  input  logic [AW-1:0] acc_addr_i,
  input  logic          acc_write_i,
  input  logic          supply_low_i,
  input  logic          nv_busy_i,
  output logic          save_req_o,
  output logic          restore_req_o
);
  logic [PN-1:0]     prefix_hit;
  logic              save_hit, restore_hit;
  logic [STEP_W-1:0] step_w;
  logic              fire_save, fire_restore;

  seq_key_match #(.AW(AW), .PN(PN)) u_match (
    .addr_i        (acc_addr_i),
    .prefix_hit_o  (prefix_hit),
    .save_hit_o    (save_hit),
    .restore_hit_o (restore_hit)
  );

  seq_step_tracker #(.PN(PN)) u_track (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .valid_i        (acc_valid_i),
    .write_i        (acc_write_i),
    .busy_i         (nv_busy_i),
    .prefix_hit_i   (prefix_hit),
    .save_hit_i     (save_hit),
    .restore_hit_i  (restore_hit),
    .step_o         (step_w),
    .fire_save_o    (fire_save),
    .fire_restore_o (fire_restore)
  );

  seq_req_stage u_req (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .fire_save_i    (fire_save),
    .fire_restore_i (fire_restore),
    .supply_low_i   (supply_low_i),
    .save_req_o     (save_req_o),
    .restore_req_o  (restore_req_o)
  );
endmodule

// File: rtl/seq_cmd_detect_chk.sv
module seq_cmd_detect_chk #(
  parameter int unsigned AW = 13,
  parameter int unsigned SW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          acc_valid_i,
  input logic [AW-1:0] acc_addr_i,
  input logic          acc_write_i,
  input logic          supply_low_i,
  input logic          nv_busy_i,
  input logic          save_req_o,
  input logic          restore_req_o,
  input logic [SW-1:0] step_i
);
  assert_one_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({save_req_o, restore_req_o}));

  assert_save_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_req_o |=> !save_req_o);

  assert_restore_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_req_o |=> !restore_req_o);

  assert_save_cause_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_req_o |-> $past(acc_valid_i && !acc_write_i && !nv_busy_i
                         && acc_addr_i == AW'(16'h0F0F)));

  assert_save_inhibit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_req_o |-> !$past(supply_low_i));

  assert_restore_cause_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_req_o |-> $past(acc_valid_i && !acc_write_i && !nv_busy_i
                            && acc_addr_i == AW'(16'h0F0E)));

  assert_write_abort_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_write_i) |=> (step_i == '0 && !save_req_o && !restore_req_o));

  assert_busy_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nv_busy_i |=> (step_i == '0 && !save_req_o && !restore_req_o));

  assert_gap_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_valid_i && !nv_busy_i) |=> $stable(step_i));
endmodule

bind seq_cmd_detect seq_cmd_detect_chk #(.AW(AW), .SW(STEP_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .acc_valid_i   (acc_valid_i),
  .acc_addr_i    (acc_addr_i),
  .acc_write_i   (acc_write_i),
  .supply_low_i  (supply_low_i),
  .nv_busy_i     (nv_busy_i),
  .save_req_o    (save_req_o),
  .restore_req_o (restore_req_o),
  .step_i        (step_w)
);

// File: tb/sim_seq_cmd_detect.sv
`timescale 1ns/1ps
module sim_seq_cmd_detect;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [12:0] addr = '0;
  logic        wr = 1'b0;
  logic        low = 1'b0;
  logic        busy = 1'b0;
  logic        save_req, restore_req;

  int checks = 0;
  int errors = 0;
  int m_step = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  seq_cmd_detect u0 (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(valid), .acc_addr_i(addr),
    .acc_write_i(wr), .supply_low_i(low), .nv_busy_i(busy),
    .save_req_o(save_req), .restore_req_o(restore_req)
  );

  function automatic logic [12:0] key(input int i);
    case (i)
      0: return 13'h0000; 1: return 13'h1555; 2: return 13'h0AAA;
      3: return 13'h1FFF; 4: return 13'h10F0; 5: return 13'h0F0F;
      default: return 13'h0F0E;
    endcase
  endfunction

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  // Model from the requirements; returns {save, restore} expected after the access
  task automatic model(input logic [12:0] a, input logic w, input logic l, input logic b,
                       output logic es, output logic er);
    es = 1'b0; er = 1'b0;
    if (b) m_step = 0;
    else if (w) m_step = 0;
    else if (m_step < 5 && a == key(m_step)) m_step++;
    else if (m_step == 5 && (a == 13'h0F0F || a == 13'h0F0E)) begin
      es = (a == 13'h0F0F) && !l;
      er = (a == 13'h0F0E);
      m_step = 0;
    end else m_step = (a == 13'h0000) ? 1 : 0;
  endtask

  task automatic access(input logic [12:0] a, input logic w, input logic l,
                        input logic b, input string tag);
    logic es, er;
    model(a, w, l, b, es, er);
    addr = a; wr = w; low = l; busy = b; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0; wr = 1'b0; low = 1'b0; busy = 1'b0;
    check(tag, save_req, es, "save_req");
    check(tag, restore_req, er, "restore_req");
  endtask

  task automatic idle(input int n, input logic b, input string tag);
    for (int i = 0; i < n; i++) begin
      busy = b;
      if (b) m_step = 0;
      @(negedge clk);
      check(tag, save_req | restore_req, 1'b0, "idle_req");
    end
    busy = 1'b0;
  endtask

  task automatic prefix(input int upto, input string tag);
    for (int i = 0; i < upto; i++) access(key(i), 1'b0, 1'b0, 1'b0, tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R8", save_req | restore_req, 1'b0, "reset");
    rst_n = 1'b1;
    @(negedge clk);

    prefix(5, "R1"); access(13'h0F0F, 0, 0, 0, "R1");
    idle(1, 0, "R8");
    prefix(5, "R2"); access(13'h0F0E, 0, 0, 0, "R2");
    prefix(5, "R6"); access(13'h0F0F, 0, 1, 0, "R6");
    prefix(5, "R6"); access(13'h0F0E, 0, 1, 0, "R6");
    // write at each position aborts
    for (int p = 0; p < 6; p++) begin
      prefix(p, "R3"); access(key(p), 1'b1, 0, 0, "R3");
      for (int i = p + 1; i < 6; i++) access(key(i), 0, 0, 0, "R3");
    end
    access(13'h0000, 1, 0, 0, "R3"); prefix(5, "R3"); access(key(5), 0, 0, 0, "R3");
    // wrong read at each position
    for (int p = 1; p < 6; p++) begin
      prefix(p, "R4"); access(13'h0123, 0, 0, 0, "R4");
      for (int i = p; i < 6; i++) access(key(i), 0, 0, 0, "R4");
    end
    prefix(5, "R4"); access(13'h0F0D, 0, 0, 0, "R4");
    prefix(3, "R5"); access(13'h0000, 0, 0, 0, "R5");
    for (int i = 1; i < 6; i++) access(key(i), 0, 0, 0, "R5");
    prefix(4, "R7"); idle(2, 1, "R7");
    access(key(4), 0, 0, 0, "R7"); access(key(5), 0, 0, 0, "R7");
    prefix(5, "R7"); access(key(5), 0, 0, 1, "R7");
    prefix(2, "R9"); idle(5, 0, "R9"); access(key(2), 0, 0, 0, "R9");
    access(key(3), 0, 0, 0, "R9"); idle(3, 0, "R9");
    access(key(4), 0, 0, 0, "R9"); access(key(5), 0, 0, 0, "R9");
    prefix(5, "R10"); access(key(6), 0, 0, 0, "R10"); access(key(6), 0, 0, 0, "R10");

    for (int n = 0; n < 4000; n++) begin
      int r;
      logic [12:0] a;
      r = int'($urandom_range(0, 99));
      if (r < 70)      a = key(m_step < 5 ? m_step : 5 + int'($urandom_range(0, 1)));
      else if (r < 80) a = 13'h0000;
      else if (r < 88) a = key(int'($urandom_range(0, 6)));
      else             a = 13'($urandom);
      access(a, $urandom_range(0, 99) < 8, $urandom_range(0, 99) < 15,
             $urandom_range(0, 99) < 3, "R4");
      if ($urandom_range(0, 9) == 0) idle(int'($urandom_range(1, 3)), 0, "R9");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule